// File: doc/BRIEF.md
# Ring Bus Always-On Node Frontend

This block is the part of a clockless ring bus node that stays powered while everything else sleeps. It has no clock of its own. Its flip-flops are clocked only by the incoming bus lines and by the local wakeup strobe. It has three jobs:

- It watches the incoming data and clock lines. It raises an in-band bus interrupt when data rises repeatedly while the clock stays still.
- It lets the local node ask for a system wakeup by pulling the outgoing data line low.
- Once the system clock reaches the node, it brings the node's gated domains up one step per bus clock rising edge.

Outgoing data is the incoming data, except while a wakeup request is being driven. Both bus lines idle high in standby.

The wake sequencer is a five-state machine clocked by the incoming bus clock:

- `ST_SLEEP` is the standby state: power off, clock gated, outputs isolated, reset held.
- `ST_POWER` is entered on the first rising edge (transition *power release*).
- `ST_CLOCK` is entered on the second edge (*clock release*).
- `ST_UNISO` is entered on the third edge (*isolation release*).
- `ST_RUN` is entered on the fourth edge (*reset release*).
- `ST_RUN` then holds on every later edge (*hold*).

Only the asynchronous power-on reset returns the machine to `ST_SLEEP`.

Top module: `ring_fe_top`

## Requirements
- R1: While `rst_n` is low, the outputs take their standby values: `dom_pwr_o`=0, `dom_clk_o`=0, `dom_iso_o`=1, `dom_rst_o`=1 and `irq_o`=0. Applying `rst_n` low at any later time returns the block to these values.
- R2: A rising edge on `wake_req_i` while the sequencer is in `ST_SLEEP` drives `bus_dout_o` to 0, whatever the value of `bus_din_i`.
- R3: While no wakeup request is being driven, `bus_dout_o` equals `bus_din_i`.
- R4: The first rising edge of `bus_clk_i` after reset sets `dom_pwr_o`=1 and leaves the other three domain outputs at their standby values. The same edge withdraws the wakeup pull, so `bus_dout_o` follows `bus_din_i` again.
- R5: The second rising edge of `bus_clk_i` sets `dom_clk_o`=1. The third sets `dom_iso_o`=0. The fourth sets `dom_rst_o`=0. Later edges change none of the domain outputs.
- R6: With `bus_clk_i` held high, `irq_o` goes to 1 on exactly the third rising edge of `bus_din_i`. One or two rising edges leave it at 0.
- R7: A low level on `bus_clk_i` clears any partial count of data edges. After that, three new rising edges of `bus_din_i` are needed to set `irq_o`.
- R8: Once set, `irq_o` stays at 1 through further bus clock and data activity until `irq_ack_i` is pulsed high, which clears it.
- R9: The domain outputs never break the release order. Clock enable implies power, isolation release implies clock enable, and reset release implies isolation release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| bus_clk_i | input | 1 | Incoming ring bus clock, idles high |
| bus_din_i | input | 1 | Incoming ring bus data, idles high |
| wake_req_i | input | 1 | Local wakeup request; its rising edge arms the pull |
| irq_ack_i | input | 1 | Bus controller acknowledge; clears the interrupt flag |
| bus_dout_o | output | 1 | Outgoing ring bus data |
| irq_o | output | 1 | Bus interrupt flag |
| dom_pwr_o | output | 1 | 1 = node power domain supplied |
| dom_clk_o | output | 1 | 1 = node clock gate open |
| dom_iso_o | output | 1 | 1 = node outputs isolated |
| dom_rst_o | output | 1 | 1 = node logic held in reset |

## Verification
The hardest situation to reach is the clearing of a partial interrupt count. It needs data edges with the clock held high, then a clock low pulse placed exactly between them. The bench drives the data and clock lines as separate pins from tasks, so it can place any number of data rises on either side of a single clock pulse. It sweeps zero to five data rises, each followed by an acknowledge, with the expected flag computed as count ≥ 3. For the split case it sweeps every count before and after the clock pulse, with the expected flag coming from the count after the pulse alone.

// File: rtl/ring_fe_pkg.sv
package ring_fe_pkg;

    typedef enum logic [2:0] {
        ST_SLEEP = 3'd0,
        ST_POWER = 3'd1,
        ST_CLOCK = 3'd2,
        ST_UNISO = 3'd3,
        ST_RUN   = 3'd4
    } wake_state_t;

    typedef struct packed {
        logic pwr;
        logic clk;
        logic iso;
        logic rst;
    } dom_ctrl_t;

    localparam dom_ctrl_t DOM_STANDBY = '{pwr: 1'b0, clk: 1'b0, iso: 1'b1, rst: 1'b1};

endpackage

// File: rtl/ring_fe_irq_detect.sv
module ring_fe_irq_detect #(
    parameter int EDGES = 3
) (
    input  logic rst_n,
    input  logic bus_clk,
    input  logic bus_din,
    input  logic ack,
    output logic irq
);
    localparam int LAST = EDGES - 1;

    logic [LAST:0] stage;
    logic          clr_n;

    // Partial count is wiped while the bus clock is low.
    assign clr_n = rst_n & bus_clk;

    generate
        for (genvar i = 0; i < LAST; i++) begin : g_cnt
            always_ff @(posedge bus_din or negedge clr_n) begin
                if (!clr_n) begin
                    stage[i] <= 1'b0;
                end else begin
                    stage[i] <= (i == 0) ? 1'b1 : stage[(i == 0) ? 0 : i - 1];
                end
            end
        end
    endgenerate

    always_ff @(posedge bus_din or negedge rst_n or posedge ack) begin
        if (!rst_n) begin
            stage[LAST] <= 1'b0;
        end else if (ack) begin
            stage[LAST] <= 1'b0;
        end else begin
            stage[LAST] <= stage[LAST] | stage[LAST - 1];
        end
    end

    assign irq = stage[LAST];

endmodule

// File: rtl/ring_fe_wake_seq.sv
module ring_fe_wake_seq
    import ring_fe_pkg::*;
(
    input  logic        rst_n,
    input  logic        bus_clk,
    output wake_state_t state,
    output dom_ctrl_t   dom
);
    wake_state_t state_q;
    wake_state_t state_d;

    always_ff @(posedge bus_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SLEEP;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SLEEP: state_d = ST_POWER;
            ST_POWER: state_d = ST_CLOCK;
            ST_CLOCK: state_d = ST_UNISO;
            ST_UNISO: state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
            default:  state_d = ST_SLEEP;
        endcase
    end

    always_comb begin
        dom = DOM_STANDBY;
        unique case (state_q)
            ST_SLEEP: dom = DOM_STANDBY;
            ST_POWER: dom = '{pwr: 1'b1, clk: 1'b0, iso: 1'b1, rst: 1'b1};
            ST_CLOCK: dom = '{pwr: 1'b1, clk: 1'b1, iso: 1'b1, rst: 1'b1};
            ST_UNISO: dom = '{pwr: 1'b1, clk: 1'b1, iso: 1'b0, rst: 1'b1};
            ST_RUN:   dom = '{pwr: 1'b1, clk: 1'b1, iso: 1'b0, rst: 1'b0};
            default:  dom = DOM_STANDBY;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/ring_fe_wake_req.sv
module ring_fe_wake_req
    import ring_fe_pkg::*;
(
    input  logic        rst_n,
    input  logic        wake_req,
    input  wake_state_t state,
    input  logic        bus_din,
    output logic        pull,
    output logic        bus_dout
);
    logic armed;

    always_ff @(posedge wake_req or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else begin
            armed <= 1'b1;
        end
    end

    assign pull     = armed & (state == ST_SLEEP);
    assign bus_dout = bus_din & ~pull;

endmodule

// File: rtl/ring_fe_top.sv
module ring_fe_top
    import ring_fe_pkg::*;
#(
    parameter int IRQ_EDGES = 3
) (
    input  logic rst_n,
    input  logic bus_clk_i,
    input  logic bus_din_i,
    input  logic wake_req_i,
    input  logic irq_ack_i,
    output logic bus_dout_o,
    output logic irq_o,
    output logic dom_pwr_o,
    output logic dom_clk_o,
    output logic dom_iso_o,
    output logic dom_rst_o
);
    wake_state_t state;
    dom_ctrl_t   dom;
    logic        pull;

    ring_fe_irq_detect #(.EDGES(IRQ_EDGES)) u_irq (
        .rst_n   (rst_n),
        .bus_clk (bus_clk_i),
        .bus_din (bus_din_i),
        .ack     (irq_ack_i),
        .irq     (irq_o)
    );

    ring_fe_wake_seq u_seq (
        .rst_n   (rst_n),
        .bus_clk (bus_clk_i),
        .state   (state),
        .dom     (dom)
    );

    ring_fe_wake_req u_req (
        .rst_n    (rst_n),
        .wake_req (wake_req_i),
        .state    (state),
        .bus_din  (bus_din_i),
        .pull     (pull),
        .bus_dout (bus_dout_o)
    );

    assign dom_pwr_o = dom.pwr;
    assign dom_clk_o = dom.clk;
    assign dom_iso_o = dom.iso;
    assign dom_rst_o = dom.rst;

endmodule

// File: rtl/ring_fe_checker.sv
module ring_fe_checker (
    input logic rst_n,
    input logic bus_clk_i,
    input logic bus_din_i,
    input logic bus_dout_o,
    input logic dom_pwr_o,
    input logic dom_clk_o,
    input logic dom_iso_o,
    input logic dom_rst_o
);
    // R9
    clk_needs_pwr_chk: assert property (@(posedge bus_clk_i) disable iff (!rst_n)
        dom_clk_o |-> dom_pwr_o);

    // R9
    uniso_needs_clk_chk: assert property (@(posedge bus_clk_i) disable iff (!rst_n)
        !dom_iso_o |-> dom_clk_o);

    // R9
    unrst_needs_uniso_chk: assert property (@(posedge bus_clk_i) disable iff (!rst_n)
        !dom_rst_o |-> !dom_iso_o);

    // R4
    pull_only_asleep_chk: assert property (@(posedge bus_clk_i) disable iff (!rst_n)
        (bus_din_i && !bus_dout_o) |-> !dom_pwr_o);

    // R5
    run_is_final_chk: assert property (@(posedge bus_clk_i) disable iff (!rst_n)
        !dom_rst_o |=> !dom_rst_o);

endmodule

bind ring_fe_top ring_fe_checker u_chk (
    .rst_n      (rst_n),
    .bus_clk_i  (bus_clk_i),
    .bus_din_i  (bus_din_i),
    .bus_dout_o (bus_dout_o),
    .dom_pwr_o  (dom_pwr_o),
    .dom_clk_o  (dom_clk_o),
    .dom_iso_o  (dom_iso_o),
    .dom_rst_o  (dom_rst_o)
);

// File: tb/tb_ring_fe_top.sv
`timescale 1ns/1ps
module tb_ring_fe_top;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0;
    logic bus_clk = 1'b1;
    logic bus_din = 1'b1;
    logic wake = 1'b0;
    logic ack = 1'b0;
    logic dout, irq, pwr, cke, iso, rsto;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    ring_fe_top dut (
        .rst_n      (rst_n),
        .bus_clk_i  (bus_clk),
        .bus_din_i  (bus_din),
        .wake_req_i (wake),
        .irq_ack_i  (ack),
        .bus_dout_o (dout),
        .irq_o      (irq),
        .dom_pwr_o  (pwr),
        .dom_clk_o  (cke),
        .dom_iso_o  (iso),
        .dom_rst_o  (rsto)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clk_pulse();
        @(negedge clk) bus_clk = 1'b0;
        @(negedge clk) bus_clk = 1'b1;
        idle(1);
    endtask

    task automatic din_pulse();
        @(negedge clk) bus_din = 1'b0;
        @(negedge clk) bus_din = 1'b1;
        idle(1);
    endtask

    task automatic do_ack();
        @(negedge clk) ack = 1'b1;
        @(negedge clk) ack = 1'b0;
        idle(1);
    endtask

    task automatic por();
        @(negedge clk) rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
    endtask

    function automatic logic [7:0] doms(input int edges);
        logic p, c, s, r;
        p = edges >= 1;
        c = edges >= 2;
        s = !(edges >= 3);
        r = !(edges >= 4);
        return {4'b0, p, c, s, r};
    endfunction

    initial begin
        idle(2);
        // R1: standby values while reset is held
        chk("R1", {4'b0, pwr, cke, iso, rsto}, doms(0));
        chk("R1 irq", {7'b0, irq}, 8'd0);
        rst_n = 1'b1;
        idle(1);

        // R3: forwarding with no request pending
        for (int v = 0; v < 2; v++) begin
            bus_din = v[0];
            idle(1);
            chk("R3", {7'b0, dout}, {7'b0, v[0]});
        end
        bus_din = 1'b1;
        idle(1);

        // R2: wakeup pull overrides data
        wake = 1'b1;
        idle(1);
        wake = 1'b0;
        for (int v = 0; v < 2; v++) begin
            bus_din = v[0];
            idle(1);
            chk("R2", {7'b0, dout}, 8'd0);
        end
        bus_din = 1'b1;
        idle(1);

        // R4 / R5: step through the release sequence
        for (int e = 1; e <= 6; e++) begin
            clk_pulse();
            chk(e == 1 ? "R4" : "R5", {4'b0, pwr, cke, iso, rsto}, doms(e));
            if (e == 1) begin
                for (int v = 0; v < 2; v++) begin
                    bus_din = v[0];
                    idle(1);
                    chk("R4 pull withdrawn", {7'b0, dout}, {7'b0, v[0]});
                end
                bus_din = 1'b1;
                idle(1);
            end
        end

        // R6: sweep data-rise counts with the clock held high
        for (int n = 0; n <= 5; n++) begin
            clk_pulse();
            for (int k = 0; k < n; k++) din_pulse();
            chk("R6", {7'b0, irq}, {7'b0, n >= 3});
            do_ack();
            chk("R8 ack clears", {7'b0, irq}, 8'd0);
        end

        // R7: a clock low between data rises restarts the count
        for (int a = 0; a <= 3; a++) begin
            for (int b = 0; b <= 3; b++) begin
                clk_pulse();
                for (int k = 0; k < a; k++) din_pulse();
                if (a < 3) begin
                    clk_pulse();
                    for (int k = 0; k < b; k++) din_pulse();
                    chk("R7", {7'b0, irq}, {7'b0, b >= 3});
                end
                do_ack();
            end
        end

        // R8: flag survives activity until acknowledged
        clk_pulse();
        for (int k = 0; k < 3; k++) din_pulse();
        clk_pulse();
        din_pulse();
        clk_pulse();
        chk("R8 sticky", {7'b0, irq}, 8'd1);
        do_ack();
        chk("R8 cleared", {7'b0, irq}, 8'd0);

        // R1: a later reset returns standby and clears the flag
        for (int k = 0; k < 3; k++) din_pulse();
        por();
        chk("R1 again", {4'b0, pwr, cke, iso, rsto}, doms(0));
        chk("R1 irq again", {7'b0, irq}, 8'd0);
        chk("R1 no pull", {7'b0, dout}, 8'd1);

        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule